// File: doc/BRIEF.md
# Programmable Tap-Select Timer Divider

A clocked timer around a 16-stage binary counter. The counter advances on every rising clock edge. A two-bit address picks one counter stage as the output source. The stage choice is not linear in the address value. The output runs in one of two ways. As a free-running divider, it gives the clock divided by 2^n. As a one-shot, it changes level once, 2^(n-1) counts after a clear, and then holds that level. A polarity input can complement the output so that it idles high instead of low.

Three sources clear the count, and with it the one-shot latch:
- a master clear, which overrides everything else and stops counting while it is held high;
- a power-on clear request, which acts only when its enable-blocking input is low;
- a rising edge on the mode input, which restarts the timer.

An address change is registered. It moves the output to the new stage from the next clock edge and leaves the count running.

Top module: `tap_timer`

## Requirements
- R1: After the asynchronous reset (rst_ni low), with invert_i low, tmr_o is low and the count starts from zero.
- R2: tap_sel_i chooses the stage count n: 2'b00 gives n=13, 2'b01 gives n=8, 2'b10 gives n=10, 2'b11 gives n=16 (bit 0 is the low address bit).
- R3: With div_mode_i high, tmr_o first changes 2^(n-1) clock edges after a clear and repeats with a period of 2^n edges.
- R4: With div_mode_i low, tmr_o changes once, 2^(n-1) edges after a clear, and keeps that level even after the selected stage falls back.
- R5: With invert_i high, tmr_o is the complement of the level it has with invert_i low.
- R6: While mreset_i is high, the count is held at zero and tmr_o stays at its idle level. Counting resumes from zero on the first edge after mreset_i falls.
- R7: A high por_req_i with por_block_i low clears the count and the latch on the next edge, exactly as mreset_i does.
- R8: A high por_req_i while por_block_i is high has no effect: the count keeps advancing.
- R9: A low-to-high change of div_mode_i, sampled on the clock, clears the one-shot latch and restarts the count from zero. A high-to-low change clears nothing.
- R10: A new tap_sel_i value drives tmr_o from the next clock edge and does not clear the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreset_i | input | 1 | Master clear, active high, overrides all other inputs |
| por_req_i | input | 1 | Power-on clear request pulse |
| por_block_i | input | 1 | High blocks por_req_i |
| tap_sel_i | input | 2 | Stage select address |
| div_mode_i | input | 1 | 1 = divider, 0 = one-shot |
| invert_i | input | 1 | Output polarity: 1 complements tmr_o |
| tmr_o | output | 1 | Timer output |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and taps at 13, 8, 10 and 16 stages. This means the full 65536-edge divider period, and the 32768-edge one-shot delay of the longest tap, both fall within the run. A behavioural model is compared with tmr_o on every cycle. Directed checks sample exactly at the 2^(n-1) and 2^n boundaries for every address. They also sample one cycle after each address change, mode edge and clear request.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_DIVIDE  = 1'b1
  } tmr_mode_e;

  localparam int unsigned NUM_TAPS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_TAPS);
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R6
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tt_tap_mux.sv
module tt_tap_mux
  import tap_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned STG0  = 13,
  parameter int unsigned STG1  = 8,
  parameter int unsigned STG2  = 10,
  parameter int unsigned STG3  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             tap_o
);
  localparam int unsigned STG [NUM_TAPS] = '{STG0, STG1, STG2, STG3};

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] mask_tab [NUM_TAPS];
  logic [CNT_W-1:0] sel_mask;

  // address takes effect one edge later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_i;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_mask
    assign mask_tab[k] = CNT_W'(1) << (STG[k] - 1);
  end

  assign sel_mask = mask_tab[sel_q];
  assign tap_o    = |(cnt_i & sel_mask);

  // R2
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_mask) == 1);
endmodule

// File: rtl/tt_out_stage.sv
module tt_out_stage
  import tap_timer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  tmr_mode_e mode_i,
  input  logic      invert_i,
  input  logic      tap_i,
  output logic      tmr_o
);
  logic latch_q;
  logic raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    latch_q <= 1'b0;
    else if (clr_i) latch_q <= 1'b0;
    else if (mode_i == MODE_ONESHOT && tap_i) latch_q <= 1'b1;
  end

  always_comb begin
    if (mode_i == MODE_DIVIDE) raw = tap_i;
    else                       raw = latch_q | tap_i;
  end

  assign tmr_o = raw ^ invert_i;

  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q && !clr_i |=> latch_q);

  // R4
  latch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !latch_q);
endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned STG0  = 13,
  parameter int unsigned STG1  = 8,
  parameter int unsigned STG2  = 10,
  parameter int unsigned STG3  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mreset_i,
  input  logic       por_req_i,
  input  logic       por_block_i,
  input  logic [1:0] tap_sel_i,
  input  logic       div_mode_i,
  input  logic       invert_i,
  output logic       tmr_o
);
  logic             mode_q;
  logic             mode_rise;
  logic             por_clr;
  logic             clr;
  logic [CNT_W-1:0] cnt;
  logic             tap;
  tmr_mode_e        mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b1;
    else         mode_q <= div_mode_i;
  end

  assign mode_rise = div_mode_i & ~mode_q;
  assign por_clr   = por_req_i & ~por_block_i;
  assign clr       = mreset_i | por_clr | mode_rise;
  assign mode      = tmr_mode_e'(div_mode_i);

  tt_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .cnt_o  (cnt)
  );

  tt_tap_mux #(
    .CNT_W(CNT_W), .STG0(STG0), .STG1(STG1), .STG2(STG2), .STG3(STG3)
  ) i_tap_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (tap_sel_i),
    .cnt_i  (cnt),
    .tap_o  (tap)
  );

  tt_out_stage i_out_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .mode_i   (mode),
    .invert_i (invert_i),
    .tap_i    (tap),
    .tmr_o    (tmr_o)
  );

  // R6
  mreset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |=> cnt == '0);

  // R8
  por_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_req_i && por_block_i && !mreset_i && !mode_rise
      |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R9
  mode_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_mode_i && !mode_q |=> cnt == '0);
endmodule

// File: tb/test_tap_timer.sv
`timescale 1ns/1ps
module test_tap_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mreset_i = 1'b0;
  logic       por_req_i = 1'b0;
  logic       por_block_i = 1'b0;
  logic [1:0] tap_sel_i = 2'b00;
  logic       div_mode_i = 1'b0;
  logic       invert_i = 1'b0;
  logic       tmr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tap_timer i_tap_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .mreset_i(mreset_i), .por_req_i(por_req_i),
    .por_block_i(por_block_i), .tap_sel_i(tap_sel_i), .div_mode_i(div_mode_i),
    .invert_i(invert_i), .tmr_o(tmr_o)
  );

  function automatic int stages(input int s);
    case (s)
      0: return 13;
      1: return 8;
      2: return 10;
      default: return 16;
    endcase
  endfunction

  // behavioural reference
  int m_cnt = 0;
  int m_sel = 0;
  bit m_latch = 0;
  bit m_prev_mode = 1;

  function automatic bit m_tap();
    return ((m_cnt >> (stages(m_sel) - 1)) & 1) != 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_sel = 0; m_latch = 0; m_prev_mode = 1;
    end else begin
      bit clr_m;
      bit t;
      t = m_tap();
      clr_m = mreset_i || (por_req_i && !por_block_i) || (div_mode_i && !m_prev_mode);
      if (clr_m) begin
        m_cnt = 0; m_latch = 0;
      end else begin
        m_cnt = (m_cnt + 1) % 65536;
        if (!div_mode_i && t) m_latch = 1;
      end
      m_prev_mode = div_mode_i;
      m_sel = int'(tap_sel_i);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tmr_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit e;
      e = (div_mode_i ? m_tap() : (m_latch | m_tap())) ^ invert_i;
      chk("R3/R4/R10 model", tmr_o, e);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic clear_pulse();
    mreset_i = 1'b1;
    tick(1);
    mreset_i = 1'b0;
  endtask

  task automatic run_divider(input int s, input bit inv);
    int h;
    h = 1 << (stages(s) - 1);
    tap_sel_i = 2'(s); div_mode_i = 1'b1; invert_i = inv;
    clear_pulse();
    chk("R3 start", tmr_o, inv);
    tick(h - 1);
    chk("R2 R3 before half", tmr_o, inv);
    tick(1);
    chk("R2 R3 half period", tmr_o, ~inv);
    tick(h);
    chk("R3 full period", tmr_o, inv);
  endtask

  task automatic run_oneshot(input int s, input int hold);
    int h;
    h = 1 << (stages(s) - 1);
    tap_sel_i = 2'(s); div_mode_i = 1'b0; invert_i = 1'b0;
    clear_pulse();
    tick(h - 1);
    chk("R2 R4 before fire", tmr_o, 1'b0);
    tick(1);
    chk("R4 fire", tmr_o, 1'b1);
    tick(hold);
    chk("R4 hold", tmr_o, 1'b1);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    chk("R1 reset level", tmr_o, 1'b0);
    tick(1);
    chk("R1 count from zero", tmr_o, 1'b0);

    for (int s = 0; s < 4; s++) run_divider(s, 1'b0);
    run_divider(1, 1'b1);  // R5
    run_divider(2, 1'b1);  // R5

    run_oneshot(1, 128);
    run_oneshot(2, 512);
    run_oneshot(0, 4096);
    run_oneshot(3, 1000);

    // R6: held master clear
    tap_sel_i = 2'd1; div_mode_i = 1'b1; invert_i = 1'b0;
    mreset_i = 1'b1;
    tick(200);
    chk("R6 held clear", tmr_o, 1'b0);
    mreset_i = 1'b0;
    tick(127);
    chk("R6 restart", tmr_o, 1'b0);
    tick(1);
    chk("R6 restart edge", tmr_o, 1'b1);

    // R7: enabled power-on request
    clear_pulse();
    tick(100);
    por_req_i = 1'b1; por_block_i = 1'b0;
    tick(1);
    por_req_i = 1'b0;
    tick(127);
    chk("R7 por clears", tmr_o, 1'b0);
    tick(1);
    chk("R7 por restart", tmr_o, 1'b1);

    // R8: blocked power-on request
    clear_pulse();
    tick(100);
    por_req_i = 1'b1; por_block_i = 1'b1;
    tick(1);
    por_req_i = 1'b0;
    tick(27);
    chk("R8 por ignored", tmr_o, 1'b1);
    por_block_i = 1'b0;

    // R9: mode rise clears latch
    div_mode_i = 1'b0;
    clear_pulse();
    tick(128);
    chk("R9 latched", tmr_o, 1'b1);
    div_mode_i = 1'b1;
    tick(1);
    chk("R9 rise restarts", tmr_o, 1'b0);
    div_mode_i = 1'b0;
    tick(1);
    chk("R9 latch cleared", tmr_o, 1'b0);
    tick(126);
    chk("R9 count from rise", tmr_o, 1'b0);
    tick(1);
    chk("R9 fires again", tmr_o, 1'b1);

    // R10: address change is registered, count kept
    tap_sel_i = 2'd1; div_mode_i = 1'b1;
    tick(1);
    div_mode_i = 1'b0;
    tick(1);
    div_mode_i = 1'b1;
    clear_pulse();
    tick(200);
    chk("R10 before change", tmr_o, 1'b1);
    tap_sel_i = 2'd2;
    #0.5;
    chk("R10 not yet", tmr_o, 1'b1);
    tick(1);
    chk("R10 next edge", tmr_o, 1'b0);
    tick(311);
    chk("R10 count kept", tmr_o, 1'b1);

    tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule